// File: doc/BRIEF.md
# JTAG Data-Register Bank with Reset-Request Chain

This block holds the data-register side of a four-bit-instruction test access port. The TAP state machine and the instruction register sit outside it. It takes the current instruction code and three one-hot state strobes, which mark the capture, shift and update states of the data-register path. It is clocked by TCK. From the instruction it picks the register that sits between TDI and TDO. Four registers are available:

- a 32-bit identification register;
- a parameterised boundary-scan chain, whose capture cells sample the pins and whose update cells hold output latches;
- a one-bit reset register, which drives a device reset request;
- a one-bit bypass register.

The reset request comes straight from the reset register bit. No update stage sits in between, so the device stays in reset for as long as that bit holds a one. The request is never fed back into the test logic.

The boundary-scan output latches are loaded on update but never drive a pin. The functional pins keep running undisturbed. The latches are only brought out as an observation port.

Top module: `tdr_bank`

## Requirements
- R1: While `trstN` is low, the code 0x1 (identification) is in effect whatever `instrCode` holds, so TDO carries identification bit 0 (a one).
- R2: Under code 0x1, a capture cycle loads {version[31:28], part number[27:12], manufacturer[11:1], 1'b1}, and each shift cycle moves it one bit, LSB first, with TDI entering at bit 31.
- R3: Under code 0x2, a capture cycle samples `pinIn` into the boundary chain, and shift cycles move it LSB first (bit 0 leaves first, TDI enters at bit BSR_LEN-1).
- R4: `latchOut` changes only on an update cycle under code 0x2, where it takes the chain contents. Updates under other codes and `trstN` leave it unchanged.
- R5: Under code 0xC, each shift cycle loads TDI into the one-bit reset register, and a capture cycle leaves it unchanged. `resetReq` equals that bit with no update stage, so it changes on the shift edge itself, while Shift-DR is still active.
- R6: An asserted `resetReq` does not disturb the scan logic: identification scans still return the expected value while it is high.
- R7: Under code 0xF, capture loads a zero into the bypass bit, and shifting gives a one-cycle delay from TDI to TDO.
- R8: Every code other than 0x1, 0x2 and 0xC selects the bypass register.
- R9: TDO is registered on the falling TCK edge from bit 0 of the selected register. `tdoEn` is registered on the same edge and is high exactly for the falling edges taken during Shift-DR.
- R10: `trstN` low asynchronously clears the reset register, the bypass bit and `tdoEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test-logic reset, active low |
| instrCode | input | 4 | Current instruction code |
| captureDr | input | 1 | TAP in Capture-DR |
| shiftDr | input | 1 | TAP in Shift-DR |
| updateDr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial test data in |
| pinIn | input | BSR_LEN | Pin values sampled by the boundary chain |
| tdo | output | 1 | Serial test data out |
| tdoEn | output | 1 | TDO output enable |
| resetReq | output | 1 | Device reset request from the reset register |
| latchOut | output | BSR_LEN | Boundary output latches, not connected to pins |

## Verification
Some behaviour is checked by the assertions on every clock:
- the capture loads of the identification, boundary and bypass registers;
- the reset bit following TDI on shift and holding otherwise;
- output latches holding except on a boundary update;
- `tdoEn` tracking Shift-DR;
- the asynchronous clears.

Other behaviour only the bench scenarios can show:
- the serial order of whole scans;
- the bypass fallback for every unlisted code;
- the forced identification selection during reset;
- the reset request surviving unrelated scans;
- the latches surviving test-logic reset.

// File: rtl/tdr_pkg.sv
`timescale 1ns/1ps
package tdr_pkg;

  localparam logic [3:0] OP_IDCODE = 4'h1;
  localparam logic [3:0] OP_SAMPLE = 4'h2;
  localparam logic [3:0] OP_RSTREQ = 4'hC;
  localparam logic [3:0] OP_BYPASS = 4'hF;

  typedef enum logic [1:0] {
    SEL_ID  = 2'd0,
    SEL_BSR = 2'd1,
    SEL_RST = 2'd2,
    SEL_BYP = 2'd3
  } sel_e;

  // Per-register strobes handed from control to datapath
  typedef struct packed {
    sel_e sel;
    logic capId;
    logic shId;
    logic capBsr;
    logic shBsr;
    logic updBsr;
    logic shRst;
    logic capByp;
    logic shByp;
  } strobe_s;

  function automatic sel_e decodeOp(input logic [3:0] op);
    case (op)
      OP_IDCODE: decodeOp = SEL_ID;
      OP_SAMPLE: decodeOp = SEL_BSR;
      OP_RSTREQ: decodeOp = SEL_RST;
      default:   decodeOp = SEL_BYP;  // OP_BYPASS and every unlisted code
    endcase
  endfunction

endpackage

// File: rtl/tdr_ctrl.sv
`timescale 1ns/1ps
module tdr_ctrl
  import tdr_pkg::*;
(
  input  logic       trstN,
  input  logic [3:0] instrCode,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       updateDr,
  output strobe_s    ctl
);

  logic [3:0] effOp;
  sel_e       sel;

  // Test-logic reset forces the identification selection
  always_comb begin
    effOp = trstN ? instrCode : OP_IDCODE;
    sel   = decodeOp(effOp);
  end

  always_comb begin
    ctl     = '0;
    ctl.sel = sel;
    case (sel)
      SEL_ID: begin
        ctl.capId = captureDr;
        ctl.shId  = shiftDr;
      end
      SEL_BSR: begin
        ctl.capBsr = captureDr;
        ctl.shBsr  = shiftDr;
        ctl.updBsr = updateDr;
      end
      SEL_RST: begin
        ctl.shRst = shiftDr;
      end
      default: begin
        ctl.capByp = captureDr;
        ctl.shByp  = shiftDr;
      end
    endcase
  end

endmodule

// File: rtl/tdr_bscell.sv
`timescale 1ns/1ps
module tdr_bscell (
  input  logic tck,
  input  logic capEn,
  input  logic shEn,
  input  logic updEn,
  input  logic pinVal,
  input  logic serIn,
  output logic chainQ,
  output logic latchQ
);

  // Capture/shift stage
  always_ff @(posedge tck) begin
    if (capEn)     chainQ <= pinVal;
    else if (shEn) chainQ <= serIn;
  end

  // Output latch: no reset, never drives a pin
  always_ff @(posedge tck) begin
    if (updEn) latchQ <= chainQ;
  end

endmodule

// File: rtl/tdr_path.sv
`timescale 1ns/1ps
module tdr_path
  import tdr_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter logic [31:0] ID_VALUE = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  strobe_s            ctl,
  input  logic [BSR_LEN-1:0] pinIn,
  output logic               tdo,
  output logic               tdoEn,
  output logic               resetReq,
  output logic [BSR_LEN-1:0] latchOut
);

  localparam int ID_W = 32;

  logic [ID_W-1:0]    idReg;
  logic [BSR_LEN-1:0] chainBits;
  logic               rstBit;
  logic               bypBit;
  logic               lsbSel;
  logic               shAny;
  logic               tdoQ;
  logic               tdoEnQ;

  // Identification register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)        idReg <= ID_VALUE;
    else if (ctl.capId) idReg <= ID_VALUE;
    else if (ctl.shId)  idReg <= {tdi, idReg[ID_W-1:1]};
  end

  // Boundary chain
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic serBit;
    if (i == BSR_LEN - 1) begin : g_head
      assign serBit = tdi;
    end else begin : g_body
      assign serBit = chainBits[i+1];
    end
    tdr_bscell u_cell (
      .tck    (tck),
      .capEn  (ctl.capBsr),
      .shEn   (ctl.shBsr),
      .updEn  (ctl.updBsr),
      .pinVal (pinIn[i]),
      .serIn  (serBit),
      .chainQ (chainBits[i]),
      .latchQ (latchOut[i])
    );
  end

  // Reset register: output taken directly, no update stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)         rstBit <= 1'b0;
    else if (ctl.shRst) rstBit <= tdi;
  end

  // Bypass register
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)          bypBit <= 1'b0;
    else if (ctl.capByp) bypBit <= 1'b0;
    else if (ctl.shByp)  bypBit <= tdi;
  end

  always_comb begin
    case (ctl.sel)
      SEL_ID:  lsbSel = idReg[0];
      SEL_BSR: lsbSel = chainBits[0];
      SEL_RST: lsbSel = rstBit;
      default: lsbSel = bypBit;
    endcase
  end

  assign shAny = ctl.shId | ctl.shBsr | ctl.shRst | ctl.shByp;

  always_ff @(negedge tck) begin
    tdoQ <= lsbSel;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tdoEnQ <= 1'b0;
    else        tdoEnQ <= shAny;
  end

  assign tdo      = tdoQ;
  assign tdoEn    = tdoEnQ;
  assign resetReq = rstBit;

endmodule

// File: rtl/tdr_bank.sv
`timescale 1ns/1ps
module tdr_bank
  import tdr_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter logic [3:0]  VERSION  = 4'h1,
  parameter logic [15:0] PART_NUM = 16'h0001,
  parameter logic [10:0] MANUF_ID = 11'h01F
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic [3:0]         instrCode,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pinIn,
  output logic               tdo,
  output logic               tdoEn,
  output logic               resetReq,
  output logic [BSR_LEN-1:0] latchOut
);

  localparam logic [31:0] ID_VALUE = {VERSION, PART_NUM, MANUF_ID, 1'b1};

  strobe_s ctl;

  tdr_ctrl u_ctrl (
    .trstN     (trstN),
    .instrCode (instrCode),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .ctl       (ctl)
  );

  tdr_path #(
    .BSR_LEN  (BSR_LEN),
    .ID_VALUE (ID_VALUE)
  ) u_path (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .ctl      (ctl),
    .pinIn    (pinIn),
    .tdo      (tdo),
    .tdoEn    (tdoEn),
    .resetReq (resetReq),
    .latchOut (latchOut)
  );

endmodule

// File: rtl/tdr_bank_chk.sv
`timescale 1ns/1ps
module tdr_bank_chk
  import tdr_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter logic [31:0] ID_VALUE = 32'h0000_0001
) (
  input logic               tck,
  input logic               trstN,
  input logic [3:0]         instrCode,
  input logic               captureDr,
  input logic               shiftDr,
  input logic               updateDr,
  input logic               tdi,
  input logic [BSR_LEN-1:0] pinIn,
  input logic               tdoEn,
  input logic               resetReq,
  input logic [BSR_LEN-1:0] latchOut,
  input logic [31:0]        idReg,
  input logic [BSR_LEN-1:0] chainBits,
  input logic               bypBit
);

  logic bypCode;
  assign bypCode = !(instrCode inside {OP_IDCODE, OP_SAMPLE, OP_RSTREQ});

  p_id_capture_r2: assert property (@(posedge tck) disable iff (!trstN)
    (captureDr && instrCode == OP_IDCODE) |=> (idReg == ID_VALUE));

  p_bsr_capture_r3: assert property (@(posedge tck) disable iff (!trstN)
    (captureDr && instrCode == OP_SAMPLE) |=> (chainBits == $past(pinIn)));

  p_latch_hold_r4: assert property (@(posedge tck) disable iff (!trstN)
    (!(updateDr && instrCode == OP_SAMPLE) && !$isunknown(latchOut)) |=> $stable(latchOut));

  p_rst_shift_r5: assert property (@(posedge tck) disable iff (!trstN)
    (shiftDr && instrCode == OP_RSTREQ) |=> (resetReq == $past(tdi)));

  p_rst_hold_r5: assert property (@(posedge tck) disable iff (!trstN)
    !(shiftDr && instrCode == OP_RSTREQ) |=> $stable(resetReq));

  p_byp_capture_r8: assert property (@(posedge tck) disable iff (!trstN)
    (captureDr && bypCode) |=> (bypBit == 1'b0));

  p_tdoen_shift_r9: assert property (@(posedge tck) disable iff (!trstN)
    $past(trstN) |-> (tdoEn == shiftDr));

  p_trst_clear_r10: assert property (@(posedge tck)
    !trstN |-> (!resetReq && !tdoEn && !bypBit));

endmodule

bind tdr_bank tdr_bank_chk #(
  .BSR_LEN  (BSR_LEN),
  .ID_VALUE (ID_VALUE)
) u_chk (
  .tck       (tck),
  .trstN     (trstN),
  .instrCode (instrCode),
  .captureDr (captureDr),
  .shiftDr   (shiftDr),
  .updateDr  (updateDr),
  .tdi       (tdi),
  .pinIn     (pinIn),
  .tdoEn     (tdoEn),
  .resetReq  (resetReq),
  .latchOut  (latchOut),
  .idReg     (u_path.idReg),
  .chainBits (u_path.chainBits),
  .bypBit    (u_path.bypBit)
);

// File: tb/tdr_bank_bench.sv
`timescale 1ns/1ps
module tdr_bank_bench;

  localparam int          BL  = 8;
  localparam logic [3:0]  VER = 4'h5;
  localparam logic [15:0] PN  = 16'hC3A7;
  localparam logic [10:0] MF  = 11'h2B6;
  localparam logic [31:0] EXP_ID = (32'(VER) << 28) | (32'(PN) << 12) | (32'(MF) << 1) | 32'd1;

  logic          tck = 1'b0;
  logic          trstN;
  logic [3:0]    instrCode;
  logic          captureDr, shiftDr, updateDr, tdi;
  logic [BL-1:0] pinIn;
  logic          tdo, tdoEn, resetReq;
  logic [BL-1:0] latchOut;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;
  logic [63:0] dout;
  logic [BL-1:0] lastLatch;

  tdr_bank #(.BSR_LEN(BL), .VERSION(VER), .PART_NUM(PN), .MANUF_ID(MF)) u_tdr_bank (
    .tck(tck), .trstN(trstN), .instrCode(instrCode), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .pinIn(pinIn),
    .tdo(tdo), .tdoEn(tdoEn), .resetReq(resetReq), .latchOut(latchOut)
  );

  always #10 tck = ~tck;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive strobes just after a rising edge, sample just after the falling edge
  task automatic tick(input logic c, input logic s, input logic u, input logic t);
    @(posedge tck); #2;
    captureDr = c; shiftDr = s; updateDr = u; tdi = t;
    @(negedge tck); #2;
  endtask

  task automatic scan(input logic [3:0] op, input int len, input logic [63:0] din,
                      input logic upd, output logic [63:0] res);
    res = '0;
    @(posedge tck); #2;
    instrCode = op; captureDr = 1'b1; shiftDr = 1'b0; updateDr = 1'b0;
    @(negedge tck); #2;
    for (int k = 0; k < len; k++) begin
      tick(1'b0, 1'b1, 1'b0, din[k]);
      res[k] = tdo;
    end
    tick(1'b0, 1'b0, upd, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!finished) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    trstN = 1'b0; instrCode = 4'h2; captureDr = 0; shiftDr = 0; updateDr = 0; tdi = 0;
    pinIn = '0;
    repeat (3) tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 reset resetReq", 64'(resetReq), 64'd0);
    chk("R10 reset tdoEn", 64'(tdoEn), 64'd0);
    chk("R1 forced id tdo", 64'(tdo), 64'd1);

    @(posedge tck); #2; trstN = 1'b1; instrCode = 4'h1;
    @(negedge tck); #2;

    // R2 identification scan
    scan(4'h1, 32, 64'hFFFF_FFFF, 1'b0, dout);
    chk("R2 id value", dout[31:0], 64'(EXP_ID));
    scan(4'h1, 32, 64'h0, 1'b0, dout);
    chk("R2 id recapture", dout[31:0], 64'(EXP_ID));

    // R3/R4 exhaustive pin and preload sweep
    for (int p = 0; p < 256; p++) begin
      logic [BL-1:0] dv;
      dv = BL'((p * 37 + 11) & 8'hFF);
      pinIn = BL'(p);
      scan(4'h2, BL, 64'(dv), 1'b1, dout);
      chk("R3 sampled pins", dout[BL-1:0], 64'(p));
      chk("R4 latch update", 64'(latchOut), 64'(dv));
      lastLatch = dv;
    end

    // R4 update under other codes leaves latches
    scan(4'h1, 32, 64'h0, 1'b1, dout);
    chk("R4 update under id", 64'(latchOut), 64'(lastLatch));
    scan(4'hF, 4, 64'hF, 1'b1, dout);
    chk("R4 update under bypass", 64'(latchOut), 64'(lastLatch));

    // R1 forced identification while trstN low
    pinIn = '0;
    scan(4'h2, BL, 64'h0, 1'b0, dout);
    chk("R3 chain lsb zero", 64'(tdo), 64'd0);
    @(posedge tck); #2; trstN = 1'b0;
    @(negedge tck); #2;
    chk("R1 forced id during reset", 64'(tdo), 64'd1);
    chk("R4 latch survives trst", 64'(latchOut), 64'(lastLatch));
    @(posedge tck); #2; trstN = 1'b1;
    @(negedge tck); #2;

    // R7/R8 bypass for every unlisted code
    for (int c = 0; c < 16; c++) begin
      logic [4:0] dv;
      if (c == 1 || c == 2 || c == 12) continue;
      dv = {c[3:0], 1'b1};
      scan(4'(c), 5, 64'(dv), 1'b0, dout);
      if (c == 15) chk("R7 bypass delay", dout[4:0], 64'((dv << 1) & 5'h1F));
      else         chk("R8 unlisted code bypass", dout[4:0], 64'((dv << 1) & 5'h1F));
    end

    // R9 output timing and enable
    @(posedge tck); #2; instrCode = 4'hF; captureDr = 1'b1;
    @(negedge tck); #2;
    chk("R9 tdoEn low outside shift", 64'(tdoEn), 64'd0);
    tick(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R9 tdoEn high in shift", 64'(tdoEn), 64'd1);
    chk("R9 tdo captured zero", 64'(tdo), 64'd0);
    tick(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 tdo shifted one", 64'(tdo), 64'd1);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 tdoEn drops", 64'(tdoEn), 64'd0);

    // R5 reset register
    scan(4'hC, 1, 64'd1, 1'b0, dout);
    chk("R5 reset req set", 64'(resetReq), 64'd1);
    chk("R5 prior bit zero", dout[0], 64'd0);
    @(posedge tck); #2; instrCode = 4'hC; captureDr = 1'b1;
    @(negedge tck); #2;
    tick(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 capture keeps bit", 64'(tdo), 64'd1);
    chk("R5 req held", 64'(resetReq), 64'd1);
    tick(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R5 unlatched clear mid-shift", 64'(resetReq), 64'd0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 unlatched set", 64'(resetReq), 64'd1);

    // R6 scans unaffected while reset request high
    scan(4'h1, 32, 64'h0, 1'b0, dout);
    chk("R6 id during reset req", dout[31:0], 64'(EXP_ID));
    chk("R6 req still high", 64'(resetReq), 64'd1);
    scan(4'h5, 3, 64'h5, 1'b0, dout);
    chk("R6 bypass during reset req", dout[2:0], 64'h2);
    chk("R6 req kept by other scan", 64'(resetReq), 64'd1);

    // R10 trst clears reset and bypass bits
    @(posedge tck); #2; instrCode = 4'hF; captureDr = 1'b1;
    @(negedge tck); #2;
    tick(1'b0, 1'b1, 1'b0, 1'b1);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 bypass bit loaded", 64'(tdo), 64'd1);
    @(posedge tck); #2; trstN = 1'b0;
    @(negedge tck); #2;
    chk("R10 trst clears req", 64'(resetReq), 64'd0);
    chk("R10 trst clears tdoEn", 64'(tdoEn), 64'd0);
    @(posedge tck); #2; trstN = 1'b1;
    @(negedge tck); #2;
    tick(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 bypass bit cleared", 64'(tdo), 64'd0);
    chk("R4 latch after trst", 64'(latchOut), 64'(lastLatch));
    tick(1'b0, 1'b0, 1'b0, 1'b0);

    finished = 1;
    summary();
    $finish;
  end

endmodule